// File: doc/BRIEF.md
# Extended-Address Prefix Word Handler

This block sits in the instruction stream just ahead of the base decoder. It watches each incoming 16-bit instruction word for the 20-bit extension prefix. A prefix word is taken off the stream and its fields are held. The next instruction word is then sent downstream with those fields attached. For each issued word the block reports the final operand width (8, 16 or 20 bits), the source and destination address-extension nibbles, the repeat controls, the zero-carry control and a flag that marks the instruction as extended.

The meaning of the prefix bits depends on the addressing of the word that follows. If that word uses registers only, the bits become a repeat count (held in a register or given directly), a zero-carry control and a repeat value. In any other case they are address-extension nibbles. The block also decodes three native extended forms that carry a count and a width bit in the word itself: rotate-multiple, push-multiple and pop-multiple.

Both the input and the output stream use valid/ready handshakes. One output register holds the decorated word. An input word is taken whenever that register is empty or is being drained in the same cycle, so `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds steady and no input is taken.

Top module: `xpfx_unit`

## Requirements
- R1: A word with bits [15:11] = 00011 and bits [5:4] = 00 is a prefix: it is consumed and produces no output word. A word that has 00011 in [15:11] but anything other than 00 in [5:4] is passed downstream as an ordinary, non-extended word.
- R2: The first non-prefix word after a prefix is issued with `out_ext`=1. When that word is not in register-only mode, `out_src_ext` is taken from prefix bits [10:7] and `out_dst_ext` from prefix bits [3:0].
- R3: For double-operand words (bits [15:12] ≥ 4) and single-operand words (bits [15:10] = 000100), the width bit is word bit 6 and the width flag is prefix bit 6. If the width flag is 1, `out_size` is 0 (8-bit) when bit 6 = 1, and 1 (16-bit) otherwise. If the width flag is 0, `out_size` is 2 (20-bit) whatever bit 6 is.
- R4: A word with no pending prefix is issued with `out_ext`=0, both nibbles 0, `out_rpt_en`=0, and a width flag of 1 applied as in R3.
- R5: Register-only mode is a double-operand word with bit 7 = 0 and bits [5:4] = 00, or a single-operand word with bits [5:4] = 00. In that mode, after a prefix, the block gives `out_rpt_en`=1, `out_rpt_reg` = prefix bit 7, `out_zc` = prefix bit 8, `out_rpt_val` = prefix bits [3:0], and both nibbles 0.
- R6: A rotate-multiple word has bits [15:12] = 0000 and bits [7:5] = 010. It is issued with `out_form`=1, `out_kind` = bits [9:8] (00 rrc, 01 rra, 10 rla, 11 rru), `out_rpt_val` = bits [11:10] zero-extended, `out_rpt_en`=1, `out_ext`=1, and `out_size` 1 when bit 4 = 1, else 2.
- R7: A word with bits [15:9] = 0001010 is push-multiple (`out_form`=2). A word with bits [15:9] = 0001011 is pop-multiple (`out_form`=3). Both give `out_rpt_val` = bits [7:4], `out_rpt_en`=1 and `out_ext`=1, with `out_size` 1 when bit 8 = 1, else 2.
- R8: A held prefix is cleared when the next non-prefix word is accepted, so the word after that is issued non-extended.
- R9: When two prefixes arrive back to back, the second one replaces the first.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs hold their values. The held word is replaced only in a cycle where `out_ready`=1.
- R11: Reset clears `out_valid` and any held prefix, and leaves `in_ready`=1.
- R12: Any other word with bits [15:12] = 0000 (an address-word form) is issued with `out_ext`=1, `out_size`=2, `out_form`=0 and both nibbles 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 16 | Incoming instruction word |
| out_valid | output | 1 | Issued word valid |
| out_ready | input | 1 | Downstream takes the issued word |
| out_word | output | 16 | Issued instruction word (unchanged) |
| out_ext | output | 1 | Instruction is extended |
| out_size | output | 2 | Operand width: 0 = 8, 1 = 16, 2 = 20 bits |
| out_src_ext | output | 4 | Source address-extension nibble |
| out_dst_ext | output | 4 | Destination address-extension nibble |
| out_rpt_en | output | 1 | Repeat controls apply |
| out_rpt_reg | output | 1 | Repeat count is held in a register |
| out_rpt_val | output | 4 | Repeat value or count field |
| out_zc | output | 1 | Zero-carry control |
| out_form | output | 2 | 0 plain, 1 rotate-multiple, 2 push-multiple, 3 pop-multiple |
| out_kind | output | 2 | Rotate kind for rotate-multiple |

## Verification
The two events that can land in the same cycle are the downstream draining the held word and a new word being accepted. The new word may be a prefix, which must empty the output, or an ordinary word, which must reload it and clear the prefix. The bench stalls the output with `out_ready` low while a second word waits at the input, checks that nothing moves, and then raises `out_ready` for a single cycle. It then checks that the new word shows up exactly one edge later with its own decoration, and that the word after it carries no prefix state.

// File: rtl/xpfx_pkg.sv
package xpfx_pkg;
  localparam int WORD_W = 16;
  localparam int EXT_W  = 4;
  localparam int CNT_W  = 4;
  localparam int HI_W   = WORD_W - 4;

  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_20 = 2'd2} opsize_e;
  typedef enum logic [1:0] {FM_PLAIN = 2'd0, FM_ROTM = 2'd1, FM_PUSHM = 2'd2, FM_POPM = 2'd3} form_e;
  typedef enum logic [2:0] {
    WK_DOUBLE, WK_SINGLE, WK_JUMP, WK_ADDR, WK_ROTM, WK_PUSHM, WK_POPM, WK_OTHER
  } wkind_e;

  typedef struct packed {
    logic             valid;
    logic [EXT_W-1:0] sx;
    logic             wflag;
    logic [EXT_W-1:0] dx;
  } pfx_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              ext;
    opsize_e           size;
    logic [EXT_W-1:0]  src;
    logic [EXT_W-1:0]  dst;
    logic              rpt_en;
    logic              rpt_reg;
    logic [CNT_W-1:0]  rpt_val;
    logic              zc;
    form_e             form;
    logic [1:0]        kind;
  } issue_t;

  // Prefix match on bits [15:4] of the word (lower nibble is not part of the pattern)
  function automatic logic is_prefix(input logic [HI_W-1:0] hi);
    return (hi[HI_W-1:HI_W-5] == 5'b00011) && (hi[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/xpfx_latch.sv
module xpfx_latch
  import xpfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [EXT_W-1:0] sx_in,
  input  logic             wflag_in,
  input  logic [EXT_W-1:0] dx_in,
  output pfx_t             held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held.valid <= 1'b0;
      held.sx    <= '0;
      held.wflag <= 1'b1;
      held.dx    <= '0;
    end else if (load) begin
      held.valid <= 1'b1;
      held.sx    <= sx_in;
      held.wflag <= wflag_in;
      held.dx    <= dx_in;
    end else if (clear) begin
      held.valid <= 1'b0;
      held.sx    <= '0;
      held.wflag <= 1'b1;
      held.dx    <= '0;
    end
  end
endmodule

// File: rtl/xpfx_classify.sv
module xpfx_classify
  import xpfx_pkg::*;
(
  input  logic [HI_W-1:0]  hi,
  output wkind_e           wk,
  output logic             regmode,
  output logic             bw,
  output logic             wbit,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       kind
);
  // hi[k] is word bit k+4
  always_comb begin
    wk      = WK_OTHER;
    regmode = 1'b0;
    bw      = hi[2];
    wbit    = 1'b0;
    cnt     = '0;
    kind    = 2'b00;
    if (hi[11:8] >= 4'd4) begin
      wk      = WK_DOUBLE;
      regmode = (hi[1:0] == 2'b00) && !hi[3];
    end else if (hi[11:9] == 3'b001) begin
      wk = WK_JUMP;
    end else if (hi[11:6] == 6'b000100) begin
      wk      = WK_SINGLE;
      regmode = (hi[1:0] == 2'b00);
    end else if (hi[11:8] == 4'b0000) begin
      if (hi[3:1] == 3'b010) begin
        wk   = WK_ROTM;
        cnt  = {2'b00, hi[7:6]};
        kind = hi[5:4];
        wbit = hi[0];
      end else begin
        wk = WK_ADDR;
      end
    end else if (hi[11:5] == 7'b0001010) begin
      wk   = WK_PUSHM;
      cnt  = hi[3:0];
      wbit = hi[4];
    end else if (hi[11:5] == 7'b0001011) begin
      wk   = WK_POPM;
      cnt  = hi[3:0];
      wbit = hi[4];
    end
  end
endmodule

// File: rtl/xpfx_merge.sv
module xpfx_merge
  import xpfx_pkg::*;
(
  input  pfx_t              held,
  input  logic [WORD_W-1:0] word,
  input  wkind_e            wk,
  input  logic              regmode,
  input  logic              bw,
  input  logic              wbit,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        kind,
  output issue_t            iss
);
  logic    wflag;
  opsize_e wide_sz;

  always_comb begin
    wflag   = held.valid ? held.wflag : 1'b1;
    wide_sz = wbit ? SZ_16 : SZ_20;
  end

  always_comb begin
    iss         = '0;
    iss.word    = word;
    iss.ext     = held.valid;
    iss.size    = SZ_16;
    iss.src     = held.valid ? held.sx : '0;
    iss.dst     = held.valid ? held.dx : '0;
    iss.form    = FM_PLAIN;
    case (wk)
      WK_DOUBLE, WK_SINGLE: begin
        iss.size = wflag ? (bw ? SZ_8 : SZ_16) : SZ_20;
        if (held.valid && regmode) begin
          iss.src     = '0;
          iss.dst     = '0;
          iss.rpt_en  = 1'b1;
          iss.rpt_reg = held.sx[0];
          iss.zc      = held.sx[1];
          iss.rpt_val = held.dx;
        end
      end
      WK_ROTM, WK_PUSHM, WK_POPM: begin
        iss.ext     = 1'b1;
        iss.src     = '0;
        iss.dst     = '0;
        iss.rpt_en  = 1'b1;
        iss.rpt_val = cnt;
        iss.size    = wide_sz;
        iss.form    = (wk == WK_ROTM) ? FM_ROTM : ((wk == WK_PUSHM) ? FM_PUSHM : FM_POPM);
        iss.kind    = (wk == WK_ROTM) ? kind : 2'b00;
      end
      WK_ADDR: begin
        iss.ext  = 1'b1;
        iss.size = SZ_20;
        iss.src  = '0;
        iss.dst  = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xpfx_unit.sv
module xpfx_unit
  import xpfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_ext,
  output logic [1:0]        out_size,
  output logic [EXT_W-1:0]  out_src_ext,
  output logic [EXT_W-1:0]  out_dst_ext,
  output logic              out_rpt_en,
  output logic              out_rpt_reg,
  output logic [CNT_W-1:0]  out_rpt_val,
  output logic              out_zc,
  output logic [1:0]        out_form,
  output logic [1:0]        out_kind
);
  logic             take, pfx_hit, take_pfx, take_ins;
  pfx_t             held;
  wkind_e           wk;
  logic             regmode, bw, wbit;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       kind;
  issue_t           iss, oreg;
  logic             ovld;

  always_comb begin
    in_ready = !ovld || out_ready;
    take     = in_valid && in_ready;
    pfx_hit  = is_prefix(in_word[WORD_W-1:4]);
    take_pfx = take && pfx_hit;
    take_ins = take && !pfx_hit;
  end

  xpfx_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(take_pfx), .clear(take_ins),
    .sx_in(in_word[10:7]), .wflag_in(in_word[6]), .dx_in(in_word[3:0]),
    .held(held)
  );

  xpfx_classify u_cls (
    .hi(in_word[WORD_W-1:4]), .wk(wk), .regmode(regmode), .bw(bw),
    .wbit(wbit), .cnt(cnt), .kind(kind)
  );

  xpfx_merge u_mrg (
    .held(held), .word(in_word), .wk(wk), .regmode(regmode), .bw(bw),
    .wbit(wbit), .cnt(cnt), .kind(kind), .iss(iss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovld <= 1'b0;
      oreg <= '0;
    end else begin
      if (take_ins) begin
        ovld <= 1'b1;
        oreg <= iss;
      end else if (out_ready) begin
        ovld <= 1'b0;
      end
    end
  end

  always_comb begin
    out_valid   = ovld;
    out_word    = oreg.word;
    out_ext     = oreg.ext;
    out_size    = oreg.size;
    out_src_ext = oreg.src;
    out_dst_ext = oreg.dst;
    out_rpt_en  = oreg.rpt_en;
    out_rpt_reg = oreg.rpt_reg;
    out_rpt_val = oreg.rpt_val;
    out_zc      = oreg.zc;
    out_form    = oreg.form;
    out_kind    = oreg.kind;
  end
endmodule

// File: rtl/xpfx_unit_chk.sv
module xpfx_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_word,
  input logic        out_ext,
  input logic [1:0]  out_size,
  input logic [3:0]  out_src_ext,
  input logic [3:0]  out_dst_ext,
  input logic        out_rpt_en,
  input logic [1:0]  out_form
);
  a_r1_prefix_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_word[15:11] == 5'b00011 && in_word[5:4] == 2'b00) |=> !out_valid);

  a_r4_plain_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ext) |-> (out_src_ext == 4'd0 && out_dst_ext == 4'd0 && !out_rpt_en));

  a_r5_rpt_no_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rpt_en && out_form == 2'd0) |-> (out_ext && out_src_ext == 4'd0 && out_dst_ext == 4'd0));

  a_r6_multi_width: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form != 2'd0) |-> (out_ext && out_rpt_en && out_size != 2'd0));

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_size) && $stable(out_ext)));

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r11_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind xpfx_unit xpfx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_ext(out_ext), .out_size(out_size),
  .out_src_ext(out_src_ext), .out_dst_ext(out_dst_ext),
  .out_rpt_en(out_rpt_en), .out_form(out_form)
);

// File: tb/xpfx_unit_bench.sv
`timescale 1ns/1ps
module xpfx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_ext, out_rpt_en, out_rpt_reg, out_zc;
  logic [15:0] out_word;
  logic [1:0]  out_size, out_form, out_kind;
  logic [3:0]  out_src_ext, out_dst_ext, out_rpt_val;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xpfx_unit u_xpfx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ext(out_ext), .out_size(out_size),
    .out_src_ext(out_src_ext), .out_dst_ext(out_dst_ext),
    .out_rpt_en(out_rpt_en), .out_rpt_reg(out_rpt_reg),
    .out_rpt_val(out_rpt_val), .out_zc(out_zc),
    .out_form(out_form), .out_kind(out_kind)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkpfx(input logic [3:0] sx, input logic wf, input logic [3:0] dx);
    return {5'b00011, sx, wf, 2'b00, dx};
  endfunction

  // Presents one word for one cycle; returns at the following negedge
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_plain(input string req, input int ext, input int sz, input int sx, input int dx);
    chk(req, "out_valid", out_valid, 1);
    chk(req, "out_ext", out_ext, ext);
    chk(req, "out_size", out_size, sz);
    chk(req, "out_src_ext", out_src_ext, sx);
    chk(req, "out_dst_ext", out_dst_ext, dx);
  endtask

  task automatic t_reset;
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "in_ready", in_ready, 1);
    send(16'h4506);
    expect_plain("R11", 0, 1, 0, 0);
  endtask

  task automatic t_plain;
    send(16'h4506);
    expect_plain("R4", 0, 1, 0, 0);
    chk("R4", "out_rpt_en", out_rpt_en, 0);
    chk("R4", "out_word", out_word, 16'h4506);
    send(16'h4546);
    expect_plain("R4", 0, 0, 0, 0);
  endtask

  task automatic t_prefix_addr;
    send(mkpfx(4'hA, 1'b1, 4'h5));
    chk("R1", "out_valid after prefix", out_valid, 0);
    send(16'h45D6);
    expect_plain("R2", 1, 0, 10, 5);
    chk("R2", "out_rpt_en", out_rpt_en, 0);
    chk("R2", "out_word", out_word, 16'h45D6);
  endtask

  task automatic t_size20_and_clear;
    send(mkpfx(4'h3, 1'b0, 4'h7));
    send(16'h45D6);
    expect_plain("R3", 1, 2, 3, 7);
    send(16'h4596);
    expect_plain("R8", 0, 1, 0, 0);
  endtask

  task automatic t_regmode;
    send(mkpfx(4'b0011, 1'b1, 4'h9));
    send(16'h4506);
    expect_plain("R5", 1, 1, 0, 0);
    chk("R5", "out_rpt_en", out_rpt_en, 1);
    chk("R5", "out_rpt_reg", out_rpt_reg, 1);
    chk("R5", "out_zc", out_zc, 1);
    chk("R5", "out_rpt_val", out_rpt_val, 9);
    send(mkpfx(4'b0000, 1'b0, 4'h3));
    send(16'h1006);
    expect_plain("R5", 1, 2, 0, 0);
    chk("R5", "single out_rpt_en", out_rpt_en, 1);
    chk("R5", "single out_rpt_reg", out_rpt_reg, 0);
    chk("R5", "single out_zc", out_zc, 0);
    chk("R5", "single out_rpt_val", out_rpt_val, 3);
  endtask

  task automatic t_not_prefix;
    send(16'h1810);
    chk("R1", "near-prefix issued", out_valid, 1);
    chk("R1", "near-prefix out_ext", out_ext, 0);
    chk("R1", "near-prefix out_word", out_word, 16'h1810);
    send(16'h4596);
    chk("R1", "following out_ext", out_ext, 0);
  endtask

  task automatic t_double_prefix;
    send(mkpfx(4'h1, 1'b0, 4'h2));
    send(mkpfx(4'hC, 1'b1, 4'hE));
    chk("R9", "out_valid between prefixes", out_valid, 0);
    send(16'h4596);
    expect_plain("R9", 1, 1, 12, 14);
  endtask

  task automatic t_rotm;
    send(16'h0A56);
    chk("R6", "out_form", out_form, 1);
    chk("R6", "out_kind", out_kind, 2);
    chk("R6", "out_rpt_val", out_rpt_val, 2);
    chk("R6", "out_ext", out_ext, 1);
    chk("R6", "out_size", out_size, 1);
    send(16'h0B46);
    chk("R6", "rru out_kind", out_kind, 3);
    chk("R6", "w0 out_size", out_size, 2);
  endtask

  task automatic t_pushpop;
    send(16'h1535);
    chk("R7", "push out_form", out_form, 2);
    chk("R7", "push out_rpt_val", out_rpt_val, 3);
    chk("R7", "push out_size", out_size, 1);
    chk("R7", "push out_ext", out_ext, 1);
    send(16'h1648);
    chk("R7", "pop out_form", out_form, 3);
    chk("R7", "pop out_rpt_val", out_rpt_val, 4);
    chk("R7", "pop out_size", out_size, 2);
  endtask

  task automatic t_addr;
    send(16'h0586);
    chk("R12", "out_form", out_form, 0);
    expect_plain("R12", 1, 2, 0, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    send(mkpfx(4'h6, 1'b1, 4'h4));
    send(16'h4596);
    expect_plain("R10", 1, 1, 6, 4);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 16'h4546;
    chk("R10", "in_ready while stalled", in_ready, 0);
    repeat (2) @(negedge clk);
    chk("R10", "held out_word", out_word, 16'h4596);
    chk("R10", "held out_src_ext", out_src_ext, 6);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "reloaded out_word", out_word, 16'h4546);
    expect_plain("R8", 0, 0, 0, 0);
    @(negedge clk);
    chk("R10", "drained out_valid", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_prefix_addr();
    t_size20_and_clear();
    t_regmode();
    t_not_prefix();
    t_double_prefix();
    t_rotm();
    t_pushpop();
    t_addr();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule